// File: doc/BRIEF.md
# Transmit Self-Check Failure Escalator

This block sits beside the transmit path of a CAN controller and acts on the result of the transmitter's self-check. A one-cycle `chk_err` pulse reports that the bit just driven did not match the bit read back from the bus. When checking is switched on with `chk_en`, each reported failure does two things. It asks the frame logic, through `err_frame_req`, to corrupt the message in flight with an error frame. It also advances a small failure counter.

After `LIMIT` accepted failures (four by default) the node is forced off the bus. While the node is off the bus, further failures are ignored. Entering this state can raise a level interrupt, which only happens if `irq_en` is set at that moment. Software clears the interrupt with `irq_ack`, which leaves the off-bus state in place. A separate recovery strobe, `busoff_clr`, returns the counter and the off-bus state to zero. When `chk_en` is low, the block takes no action on a failure.

Top module: `tx_check_escalator`

## Requirements
- R1: While `chk_en` is 0, a `chk_err` pulse produces no `err_frame_req` and leaves `fail_cnt` unchanged.
- R2: With `chk_en` at 1 and `bus_off` at 0, a `chk_err` pulse in cycle N makes `err_frame_req` high for exactly cycle N+1 only.
- R3: Each failure accepted under R2 raises `fail_cnt` by exactly 1, visible in cycle N+1.
- R4: The accepted failure that brings `fail_cnt` to `LIMIT` (4) sets `bus_off` in the same cycle in which the count shows 4.
- R5: `irq` rises together with `bus_off` only if `irq_en` was 1 in the cycle of the failure that caused the entry; otherwise `irq` stays 0.
- R6: `irq` stays high until an `irq_ack` cycle, after which it is 0. `irq_ack` does not change `bus_off` or `fail_cnt`.
- R7: While `bus_off` is 1, `chk_err` pulses produce no `err_frame_req`, and `fail_cnt` stays at `LIMIT`. `fail_cnt` never exceeds `LIMIT`.
- R8: A `busoff_clr` cycle sets `fail_cnt` and `bus_off` to 0 on the next cycle. It takes priority over a simultaneous accepted failure, and no interrupt is raised in that case.
- R9: While `rst_n` is low, `fail_cnt`, `bus_off`, `irq` and `err_frame_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Enables intervention on self-check failures |
| chk_err | input | 1 | One-cycle pulse: self-check failure detected |
| irq_en | input | 1 | Allows an interrupt on entry to the off-bus state |
| irq_ack | input | 1 | Clears a pending interrupt |
| busoff_clr | input | 1 | Recovery strobe: clears counter and off-bus state |
| err_frame_req | output | 1 | One-cycle request to send an error frame |
| fail_cnt | output | CNT_W (3) | Accepted failure count, saturating at LIMIT |
| bus_off | output | 1 | Node forced off the bus |
| irq | output | 1 | Pending off-bus interrupt, level |

## Verification
The bench builds the block with the default `LIMIT` of 4, which gives a 3-bit counter. With these values the counter saturates after only a few pulses, so a short random run passes through the saturation value and the recovery path many times. It also repeatedly hits the case where a recovery strobe and a failure arrive in the same cycle. Directed sequences cover the single-cycle error-frame pulse, interrupt gating by `irq_en` at the moment of entry, and an acknowledge that leaves the off-bus state in place.

// File: rtl/tce_pkg.sv
package tce_pkg;

    typedef struct packed {
        logic accept;
        logic clear;
        logic ack;
        logic int_en;
    } tce_ctrl_t;

    function automatic logic failure_taken(input logic en, input logic err, input logic off);
        return en && err && !off;
    endfunction

endpackage

// File: rtl/tce_fail_counter.sv
module tce_fail_counter #(
    parameter int LIMIT = 4,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt,
    output logic             off,
    output logic             entering
);

    localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             off;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        entering = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
            st_d.off = 1'b0;
        end else if (accept && !st_q.off) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_V) begin
                st_d.off = 1'b1;
                entering = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign off = st_q.off;

    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !clear) |=> $stable(cnt));

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !clear && !off) |=> (cnt == $past(cnt) + 1'b1));

    p_off_at_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LIM_V) |-> off);

    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM_V);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0 && !off));

endmodule

// File: rtl/tce_irq_latch.sv
module tce_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic int_en,
    input  logic ack,
    output logic irq
);

    typedef struct packed {
        logic pend;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raise && int_en) begin
            st_d.pend = 1'b1;
        end else if (ack) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pend;

    p_gated_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(int_en) && $past(raise)));

    p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

endmodule

// File: rtl/tx_check_escalator.sv
module tx_check_escalator #(
    parameter int LIMIT = 4,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic             chk_err,
    input  logic             irq_en,
    input  logic             irq_ack,
    input  logic             busoff_clr,
    output logic             err_frame_req,
    output logic [CNT_W-1:0] fail_cnt,
    output logic             bus_off,
    output logic             irq
);
    import tce_pkg::*;

    typedef struct packed {
        logic frame;
    } top_state_t;

    tce_ctrl_t  ctrl;
    top_state_t st_d, st_q;
    logic       entering;

    always_comb begin
        ctrl.accept = failure_taken(chk_en, chk_err, bus_off);
        ctrl.clear  = busoff_clr;
        ctrl.ack    = irq_ack;
        ctrl.int_en = irq_en;
        st_d.frame  = ctrl.accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_frame_req = st_q.frame;

    tce_fail_counter #(.LIMIT(LIMIT)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (ctrl.accept),
        .clear    (ctrl.clear),
        .cnt      (fail_cnt),
        .off      (bus_off),
        .entering (entering)
    );

    tce_irq_latch u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise  (entering),
        .int_en (ctrl.int_en),
        .ack    (ctrl.ack),
        .irq    (irq)
    );

    p_no_action_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> !err_frame_req);

    p_frame_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && chk_err && !bus_off) |=> err_frame_req);

    p_frame_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame_req |=> (!err_frame_req || $past(chk_err && chk_en)));

    p_ack_keeps_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && bus_off && !busoff_clr) |=> bus_off);

    p_ignore_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |=> !err_frame_req);

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |-> (fail_cnt == '0 && !bus_off && !irq && !err_frame_req));

endmodule

// File: tb/tx_check_escalator_tb.sv
module tx_check_escalator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LIM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chk_en = 1'b0, chk_err = 1'b0, irq_en = 1'b0, irq_ack = 1'b0, busoff_clr = 1'b0;
    logic       err_frame_req, bus_off, irq;
    logic [2:0] fail_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // behavioural reference
    int m_cnt = 0;
    bit m_off = 0, m_irq = 0, m_frame = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_check_escalator u_dut (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .chk_err(chk_err),
        .irq_en(irq_en), .irq_ack(irq_ack), .busoff_clr(busoff_clr),
        .err_frame_req(err_frame_req), .fail_cnt(fail_cnt),
        .bus_off(bus_off), .irq(irq)
    );

    always @(posedge clk) begin
        bit take;
        bit enter;
        if (!rst_n) begin
            m_cnt = 0; m_off = 0; m_irq = 0; m_frame = 0;
        end else begin
            take  = chk_en && chk_err && !m_off;
            enter = take && !busoff_clr && (m_cnt == LIM - 1);
            m_frame = take;
            if (busoff_clr) begin
                m_cnt = 0; m_off = 0;
            end else if (take) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == LIM) m_off = 1;
            end
            if (enter && irq_en) m_irq = 1;
            else if (irq_ack)    m_irq = 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            check("R2 frame vs model",   err_frame_req, m_frame);
            check("R3 count vs model",   fail_cnt,      m_cnt);
            check("R4 busoff vs model",  bus_off,       m_off);
            check("R5 irq vs model",     irq,           m_irq);
        end
        if (cycles > 20000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic step(input bit en, input bit err, input bit ie, input bit ack, input bit clr);
        chk_en = en; chk_err = err; irq_en = ie; irq_ack = ack; busoff_clr = clr;
        @(posedge clk);
        @(negedge clk);
        chk_err = 0; irq_ack = 0; busoff_clr = 0;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        // R9 reset state
        check("R9 cnt in reset", fail_cnt, 0);
        check("R9 busoff in reset", bus_off, 0);
        check("R9 irq in reset", irq, 0);
        check("R9 frame in reset", err_frame_req, 0);
        rst_n = 1;
        @(negedge clk);

        // R1 disabled check does nothing
        for (int i = 0; i < 3; i++) begin
            step(0, 1, 1, 0, 0);
            check("R1 no frame when disabled", err_frame_req, 0);
            check("R1 count unchanged when disabled", fail_cnt, 0);
        end

        // R2 / R3 single failure
        step(1, 1, 1, 0, 0);
        check("R2 frame after failure", err_frame_req, 1);
        check("R3 count to 1", fail_cnt, 1);
        step(1, 0, 1, 0, 0);
        check("R2 frame only one cycle", err_frame_req, 0);

        // R4 / R5 reach limit with interrupt enabled
        for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0);
        check("R4 count at limit", fail_cnt, 4);
        check("R4 busoff set", bus_off, 1);
        check("R5 irq raised when enabled", irq, 1);

        // R7 ignored while off
        step(1, 1, 1, 0, 0);
        check("R7 no frame while off", err_frame_req, 0);
        check("R7 count saturated", fail_cnt, 4);

        // R6 hold and ack
        step(1, 0, 1, 0, 0);
        step(1, 0, 1, 0, 0);
        check("R6 irq held", irq, 1);
        step(1, 0, 1, 1, 0);
        check("R6 irq cleared by ack", irq, 0);
        check("R6 busoff kept after ack", bus_off, 1);
        check("R6 count kept after ack", fail_cnt, 4);

        // R8 clear
        step(1, 1, 1, 0, 1);
        check("R8 count cleared", fail_cnt, 0);
        check("R8 busoff cleared", bus_off, 0);

        // R5 gated off
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0);
        check("R5 busoff without irq", bus_off, 1);
        check("R5 irq stays low when disabled", irq, 0);
        step(1, 0, 0, 0, 1);

        // R8 priority over failure at the limiting step
        for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0);
        step(1, 1, 1, 0, 1);
        check("R8 clear wins over limit failure", fail_cnt, 0);
        check("R8 no busoff on clear", bus_off, 0);
        check("R8 no irq on clear", irq, 0);

        // random traffic against model
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 8) != 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
                 ($urandom % 5) == 0, ($urandom % 9) == 0);
        end

        // R9 reset mid-run
        for (int i = 0; i < 2; i++) step(1, 1, 1, 0, 1);
        step(1, 1, 1, 0, 0);
        rst_n = 0;
        @(negedge clk);
        check("R9 cnt cleared by reset", fail_cnt, 0);
        check("R9 frame cleared by reset", err_frame_req, 0);
        check("R9 irq cleared by reset", irq, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule